// File: doc/BRIEF.md
# Key-Guarded System Configuration Register

This block is a small system-control register file on a word-wide register bus. It holds one protected device-configuration word. That word drives a feature-enable output and contains a software-reset control bit. The configuration word can only be changed by a write that comes straight after a key write to a separate lock register. Any write that arrives without that key is dropped and the bus gives no indication of it.

Each key grants exactly one bus write. The next write to any address uses up the grant, whether or not that write lands. Software therefore writes the key before every protected write. A software reset takes two keyed writes: the first sets the reset bit and the second clears it. The block emits a one-cycle reset request when the bit falls. Reads have no side effects and return the lock state or the stored configuration word.

Top module: `keyed_sysctl`

## Requirements
- R1: After synchronous reset the block is locked, the configuration word reads 0, `feat_en` is 0 and `rst_req` is 0.
- R2: Writing exactly 0x000000AA to the lock register (byte offset 0xC0) unlocks the block. A read of 0xC0 returns 1 while unlocked and 0 while locked, in bit 0 with all other bits zero.
- R3: A write to the configuration register (offset 0x80) while locked leaves its stored value unchanged.
- R4: A write to 0x80 while unlocked stores the full 32-bit write data, and a read of 0x80 returns it from the next cycle on.
- R5: Any bus write to an address other than 0xC0 relocks the block, whether or not the write was accepted. This includes unmapped addresses and a second write to 0x80.
- R6: A write of any value other than 0x000000AA to 0xC0 relocks the block. Writing the key again while unlocked keeps it unlocked.
- R7: `feat_en` equals bit 23 of the stored configuration word.
- R8: `rst_req` is high for exactly one cycle, in the cycle after an accepted configuration write that changes bit 31 from 1 to 0. It stays low when bit 31 is set, and when a clearing write is rejected.
- R9: Cycles without a bus write, including reads, change neither the lock state nor the configuration word.
- R10: Reads of any offset other than 0x80 and 0xC0 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| feat_en | output | 1 | Coprocessor feature enable (configuration bit 23) |
| rst_req | output | 1 | One-cycle software reset request |

## Verification
The hardest case to reach is a reset request that arrives through the full sequence. That sequence is a key, a write setting bit 31, a second key, then a write clearing bit 31. A second way to fail is a stray write between a key and its target, which silently voids the unlock. Random stimulus rarely builds that chain, so the bench weights key writes heavily and lets random protected writes flip bit 31. Directed sequences then cover three cases: the full reset handshake, the same handshake with the second key missing, and a key followed by an unmapped write and then a protected write.

// File: rtl/sysk_pkg.sv
package sysk_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] LOCK_OFS   = 8'hC0;
    localparam logic [ADDR_W-1:0] CFG_OFS    = 8'h80;
    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_00AA;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LOCK = 2'd1,
        SEL_CFG  = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic                wr;
        reg_sel_e            sel;
        logic [DATA_W-1:0]   data;
    } bus_req_t;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        if (a == LOCK_OFS)
            return SEL_LOCK;
        else if (a == CFG_OFS)
            return SEL_CFG;
        else
            return SEL_NONE;
    endfunction

endpackage

// File: rtl/sysk_decode.sv
module sysk_decode
    import sysk_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output bus_req_t          req
);
    always_comb begin
        req.wr   = wr;
        req.sel  = decode_ofs(addr);
        req.data = wdata;
    end
endmodule

// File: rtl/sysk_unlock.sv
module sysk_unlock
    import sysk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output logic     unlocked
);
    // One grant per key: any write either re-arms (key to lock) or consumes.
    always_ff @(posedge clk) begin
        if (rst)
            unlocked <= 1'b0;
        else if (req.wr) begin
            if (req.sel == SEL_LOCK)
                unlocked <= (req.data == UNLOCK_KEY);
            else
                unlocked <= 1'b0;
        end
    end

    // R1: block starts locked after reset
    p_reset_locked_r1: assert property (@(posedge clk) rst |=> !unlocked);

    // R5: a write elsewhere always leaves the block locked
    p_consume_r5: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel != SEL_LOCK) |=> !unlocked);

    // R9: no write, no change to the lock state
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !req.wr |=> $stable(unlocked));
endmodule

// File: rtl/sysk_cfg.sv
module sysk_cfg
    import sysk_pkg::*;
#(
    parameter int FEAT_BIT  = 23,
    parameter int SWRST_BIT = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic              unlocked,
    output logic [DATA_W-1:0] cfg_q,
    output logic              feat_en,
    output logic              rst_req
);
    logic hit;
    logic accept;

    always_comb begin
        hit    = req.wr && (req.sel == SEL_CFG);
        accept = hit && unlocked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= accept && cfg_q[SWRST_BIT] && !req.data[SWRST_BIT];
            if (accept)
                cfg_q <= req.data;
        end
    end

    assign feat_en = cfg_q[FEAT_BIT];

    // R3: a rejected protected write keeps the stored word
    p_guard_r3: assert property (@(posedge clk) disable iff (rst)
        (hit && !unlocked) |=> $stable(cfg_q));

    // R8: the reset request never lasts two cycles
    p_pulse_width_r8: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R8: a request only follows a falling reset bit
    p_pulse_cause_r8: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> ($past(cfg_q[SWRST_BIT]) && !cfg_q[SWRST_BIT]));
endmodule

// File: rtl/keyed_sysctl.sv
module keyed_sysctl
    import sysk_pkg::*;
#(
    parameter int FEAT_BIT  = 23,
    parameter int SWRST_BIT = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              feat_en,
    output logic              rst_req
);
    bus_req_t          req;
    logic              unlocked;
    logic [DATA_W-1:0] cfg_q;

    sysk_decode u_dec (
        .addr  (bus_addr),
        .wr    (bus_wr),
        .wdata (bus_wdata),
        .req   (req)
    );

    sysk_unlock u_lock (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .unlocked (unlocked)
    );

    sysk_cfg #(
        .FEAT_BIT  (FEAT_BIT),
        .SWRST_BIT (SWRST_BIT)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .unlocked (unlocked),
        .cfg_q    (cfg_q),
        .feat_en  (feat_en),
        .rst_req  (rst_req)
    );

    always_comb begin
        unique case (req.sel)
            SEL_LOCK: bus_rdata = {{(DATA_W-1){1'b0}}, unlocked};
            SEL_CFG:  bus_rdata = cfg_q;
            default:  bus_rdata = '0;
        endcase
    end

    // R4: an accepted write is visible on readback the next cycle
    p_store_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && req.sel == SEL_CFG && unlocked) |=> (cfg_q == $past(bus_wdata)));

    // R10: unmapped offsets read as zero
    p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
        (req.sel == SEL_NONE) |-> (bus_rdata == '0));
endmodule

// File: tb/keyed_sysctl_tb_top.sv
`timescale 1ns/100ps
module keyed_sysctl_tb_top;
    localparam logic [7:0]  A_LOCK = 8'hC0;
    localparam logic [7:0]  A_CFG  = 8'h80;
    localparam logic [31:0] KEY    = 32'h0000_00AA;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        feat_en;
    logic        rst_req;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // model state
    bit          m_unl = 0;
    logic [31:0] m_cfg = '0;
    bit          m_pulse = 0;

    always #2.5 clk = ~clk;

    keyed_sysctl dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .feat_en(feat_en), .rst_req(rst_req)
    );

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (a == A_LOCK) return {31'b0, m_unl};
        if (a == A_CFG)  return m_cfg;
        return 32'h0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_wr(input logic [7:0] a, input logic [31:0] d);
        m_pulse = (a == A_CFG) && m_unl && m_cfg[31] && !d[31];
        if (a == A_LOCK) m_unl = (d == KEY);
        else begin
            if (a == A_CFG && m_unl) m_cfg = d;
            m_unl = 0;
        end
    endtask

    // write, then check pulse and feature output in the cycle after the edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_wr(a, d);
        chk("R8 rst_req after write", {31'b0, rst_req}, {31'b0, m_pulse});
        chk("R7 feat_en", {31'b0, feat_en}, {31'b0, m_cfg[23]});
    endtask

    // read: one idle cycle, also proves a pulse has ended
    task automatic rd(input logic [7:0] a, input string req);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1;
        chk(req, bus_rdata, exp_read(a));
        chk("R8 rst_req single cycle", {31'b0, rst_req}, 32'h0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(A_LOCK, "R1 locked after reset");
        rd(A_CFG, "R1 cfg zero after reset");
        chk("R1 feat_en", {31'b0, feat_en}, 32'h0);

        // R3 unkeyed write dropped
        wr(A_CFG, 32'h0080_0000);
        rd(A_CFG, "R3 unkeyed write dropped");
        // R2, R4, R7 keyed write
        wr(A_LOCK, KEY);
        rd(A_LOCK, "R2 unlocked reads 1");
        rd(A_LOCK, "R9 read keeps unlock");
        wr(A_CFG, 32'h0080_1234);
        rd(A_CFG, "R4 keyed write stored");
        rd(A_LOCK, "R5 write consumed unlock");
        // R5 second write without new key
        wr(A_CFG, 32'h0);
        rd(A_CFG, "R5 second write dropped");
        // R5 unmapped write between key and target
        wr(A_LOCK, KEY);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, "R10 unmapped reads zero");
        wr(A_CFG, 32'h0);
        rd(A_CFG, "R5 stray write voids key");
        // R6 bad key relocks, key twice stays unlocked
        wr(A_LOCK, KEY);
        wr(A_LOCK, 32'h0000_01AA);
        rd(A_LOCK, "R6 bad key relocks");
        wr(A_LOCK, KEY);
        wr(A_LOCK, KEY);
        rd(A_LOCK, "R6 key twice stays unlocked");
        // R8 full reset handshake
        wr(A_CFG, 32'h8080_0000);
        chk("R8 no pulse on set", {31'b0, rst_req}, 32'h0);
        wr(A_LOCK, KEY);
        wr(A_CFG, 32'h0080_0000);
        chk("R8 pulse on clear", {31'b0, rst_req}, 32'h1);
        rd(A_CFG, "R8 cfg after clear");
        // R8 clear without key: no pulse
        wr(A_LOCK, KEY);
        wr(A_CFG, 32'h8000_0000);
        wr(A_CFG, 32'h0);
        chk("R8 rejected clear no pulse", {31'b0, rst_req}, 32'h0);
        rd(A_CFG, "R3 cfg keeps bit31");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int k;
            logic [7:0] a;
            logic [31:0] d;
            k = $urandom_range(0, 9);
            d = $urandom;
            if (k < 4) wr(A_LOCK, KEY);
            else if (k < 7) wr(A_CFG, d);
            else if (k == 7) wr(A_LOCK, d);
            else if (k == 8) begin
                a = $urandom;
                wr(a, d);
            end else begin
                a = ($urandom_range(0, 2) == 0) ? A_LOCK :
                    ($urandom_range(0, 1) == 0) ? A_CFG : 8'($urandom);
                rd(a, "R9 R10 random readback");
            end
        end
        rd(A_CFG, "R4 final cfg");
        rd(A_LOCK, "R2 final lock");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule